// File: doc/BRIEF.md
# ASCII Decimal Adjust Unit

This unit corrects a 16-bit high:low byte pair after or before unpacked decimal arithmetic. It supports four adjust operations. Two correct a byte pair after a binary addition or subtraction of unpacked digits. The third folds two unpacked digits into one binary byte ahead of a division. The fourth splits a binary byte into two unpacked digits after a multiplication. Each operation produces the corrected value together with carry, auxiliary carry, overflow, sign, zero and parity flags.

An operation starts with a one-cycle pulse on `start_i`. The unit captures the opcode, the operand, the incoming auxiliary carry and the incoming overflow flag. It then returns the result with a one-cycle `done_o` pulse after a fixed latency:
- The add adjust, the subtract adjust and the fold take one cycle.
- The split takes eight cycles, because it divides by ten with an iterative restoring divider that retires one quotient bit per cycle.

The outputs hold their values until the next `done_o`.

Top module: `ascii_adj_unit`

## Requirements
- R1: Opcode 0 (add adjust). When the low nibble of the low byte is greater than 9, or `af_i` is 1, the result is (operand + 0x0106) mod 65536 masked with 0xFF0F, and `af_o` = `cf_o` = 1. Otherwise the result is the operand masked with 0xFF0F, and `af_o` = `cf_o` = 0.
- R2: Opcode 1 (subtract adjust). This uses the same condition as R1. When it holds, the result is (operand − 0x0106) mod 65536 masked with 0xFF0F, and `af_o` = `cf_o` = 1. Otherwise the result is the operand masked with 0xFF0F, and both flags are 0.
- R3: For opcodes 0 and 1:
  - `sf_o` = 0.
  - `of_o` equals the `of_i` value captured at start.
  - `zf_o` = 1 exactly when the 16-bit result is zero.
  - `pf_o` = 1 exactly when the result's bits 7:0 hold an even number of ones.
- R4: Opcode 2 (fold) returns 0x00 in bits 15:8. Bits 7:0 hold (low byte + 10 × high byte) mod 256.
- R5: Opcode 3 (split) returns low byte / 10 in bits 15:8 and low byte mod 10 in bits 7:0. Both are exact for all 256 low-byte values, and the high byte of the operand is ignored.
- R6: For opcodes 2 and 3:
  - `cf_o`, `af_o` and `of_o` are 0.
  - `sf_o` equals result bit 7.
  - `zf_o` and `pf_o` follow the rule of R3.
- R7: Latency and handshake.
  - `start_i` is accepted on a clock edge while `busy_o` is 0.
  - `done_o` rises on the 1st edge after acceptance for opcodes 0 to 2, and on the 8th edge for opcode 3.
  - `done_o` lasts one cycle.
  - `busy_o` is 1 from the accepting edge up to the edge that raises `done_o`.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. It produces no extra `done_o` and does not change the result of the operation in flight.
- R9: After reset all outputs are 0.
- R10: `res_o` and all flag outputs keep their values between `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| op_i | input | 2 | Opcode: 0 add adjust, 1 subtract adjust, 2 fold, 3 split |
| val_i | input | 16 | Operand, high byte in bits 15:8 |
| af_i | input | 1 | Incoming auxiliary carry |
| of_i | input | 1 | Incoming overflow flag, passed through by opcodes 0 and 1 |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle result-valid pulse |
| res_o | output | 16 | Adjusted value |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (1 for even) |

## Verification
The bench sweeps all 256 low-byte values through the split. A divider that restores wrongly or drops a quotient bit shows up first at the multiples of ten and at values above 200.

It drives the add and subtract adjusts at several boundaries:
- A nibble of exactly 9 against 10, where an off-by-one condition would adjust too early or too late.
- `af_i` set over a small nibble, which a design that ignores the incoming auxiliary carry leaves uncorrected.
- Operands where the 0x0106 step wraps through zero, which expose a missing 0xFF0F mask or a zero flag computed before masking.

It folds 0xFFFF to check the modulo-256 truncation. It also pulses `start_i` during both short and long operations, where a unit that restarts would return a second `done_o` or a corrupted quotient.

// File: rtl/ascii_adj_pkg.sv
package ascii_adj_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int RADIX  = 10;
    localparam int REM_W  = $clog2(2 * RADIX);
    localparam int CNT_W  = $clog2(BYTE_W);

    // +1 on the high byte, +(16 - RADIX) on the low byte
    localparam logic [WORD_W-1:0] CORR =
        WORD_W'((1 << BYTE_W) + ((1 << NIB_W) - RADIX));
    // keep the whole high byte and the low nibble of the low byte
    localparam logic [WORD_W-1:0] KEEP =
        WORD_W'(((1 << BYTE_W) - 1) << BYTE_W) | WORD_W'((1 << NIB_W) - 1);

    typedef enum logic [1:0] {
        ADJ_ADD   = 2'd0,
        ADJ_SUB   = 2'd1,
        ADJ_FOLD  = 2'd2,
        ADJ_SPLIT = 2'd3
    } adj_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } adj_st_e;

    typedef struct packed {
        logic cf;
        logic af;
        logic of;
        logic sf;
        logic zf;
        logic pf;
    } adj_flags_t;

endpackage

// File: rtl/ascii_adj_simple.sv
module ascii_adj_simple
    import ascii_adj_pkg::*;
(
    input  adj_op_e             op_i,
    input  logic [WORD_W-1:0]   val_i,
    input  logic                af_i,
    output logic [WORD_W-1:0]   res_o,
    output logic                adj_o
);

    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;
    logic [BYTE_W-1:0] tens;
    logic [WORD_W-1:0] inc_v;
    logic [WORD_W-1:0] dec_v;

    always_comb begin
        lo_b  = val_i[BYTE_W-1:0];
        hi_b  = val_i[WORD_W-1:BYTE_W];
        adj_o = (lo_b[NIB_W-1:0] > NIB_W'(RADIX - 1)) || af_i;
        tens  = BYTE_W'(hi_b * BYTE_W'(RADIX));
        inc_v = val_i + CORR;
        dec_v = val_i - CORR;
        unique case (op_i)
            ADJ_ADD:  res_o = (adj_o ? inc_v : val_i) & KEEP;
            ADJ_SUB:  res_o = (adj_o ? dec_v : val_i) & KEEP;
            default:  res_o = {{BYTE_W{1'b0}}, BYTE_W'(lo_b + tens)};
        endcase
    end

endmodule

// File: rtl/ascii_adj_div_step.sv
module ascii_adj_div_step
    import ascii_adj_pkg::*;
(
    input  logic [REM_W-2:0] rem_i,
    input  logic             bit_i,
    output logic [REM_W-2:0] rem_o,
    output logic             q_o
);

    logic [REM_W-1:0] trial;

    always_comb begin
        trial = {rem_i, bit_i};
        q_o   = (trial >= REM_W'(RADIX));
        rem_o = q_o ? (REM_W-1)'(trial - REM_W'(RADIX)) : trial[REM_W-2:0];
    end

endmodule

// File: rtl/ascii_adj_flags.sv
module ascii_adj_flags
    import ascii_adj_pkg::*;
(
    input  adj_op_e           op_i,
    input  logic [WORD_W-1:0] res_i,
    input  logic              adj_i,
    input  logic              of_i,
    output adj_flags_t        fl_o
);

    always_comb begin
        fl_o.zf = (res_i == '0);
        fl_o.pf = ~^res_i[BYTE_W-1:0];
        if (op_i == ADJ_ADD || op_i == ADJ_SUB) begin
            fl_o.cf = adj_i;
            fl_o.af = adj_i;
            fl_o.of = of_i;
            fl_o.sf = 1'b0;
        end else begin
            fl_o.cf = 1'b0;
            fl_o.af = 1'b0;
            fl_o.of = 1'b0;
            fl_o.sf = res_i[BYTE_W-1];
        end
    end

endmodule

// File: rtl/ascii_adj_unit.sv
module ascii_adj_unit
    import ascii_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] val_i,
    input  logic              af_i,
    input  logic              of_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] res_o,
    output logic              cf_o,
    output logic              af_o,
    output logic              of_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o
);

    typedef struct packed {
        adj_st_e            st;
        adj_op_e            op;
        logic [WORD_W-1:0]  val;
        logic               af_in;
        logic               of_in;
        logic [BYTE_W-1:0]  dvd;
        logic [BYTE_W-2:0]  quo;
        logic [REM_W-2:0]   rem;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [WORD_W-1:0]  res;
        adj_flags_t         fl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] simple_res;
    logic              simple_adj;
    logic [REM_W-2:0]  rem_nxt;
    logic              q_bit;
    logic [WORD_W-1:0] split_res;
    logic [WORD_W-1:0] cand_res;
    adj_flags_t        cand_fl;

    ascii_adj_simple u_simple (
        .op_i  (ctl_q.op),
        .val_i (ctl_q.val),
        .af_i  (ctl_q.af_in),
        .res_o (simple_res),
        .adj_o (simple_adj)
    );

    ascii_adj_div_step u_step (
        .rem_i (ctl_q.rem),
        .bit_i (ctl_q.dvd[BYTE_W-1]),
        .rem_o (rem_nxt),
        .q_o   (q_bit)
    );

    always_comb begin
        split_res = {ctl_q.quo, q_bit, {(BYTE_W-REM_W+1){1'b0}}, rem_nxt};
        cand_res  = (ctl_q.op == ADJ_SPLIT) ? split_res : simple_res;
    end

    ascii_adj_flags u_flags (
        .op_i  (ctl_q.op),
        .res_i (cand_res),
        .adj_i (simple_adj),
        .of_i  (ctl_q.of_in),
        .fl_o  (cand_fl)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_BUSY;
                    ctl_d.op    = adj_op_e'(op_i);
                    ctl_d.val   = val_i;
                    ctl_d.af_in = af_i;
                    ctl_d.of_in = of_i;
                    ctl_d.dvd   = val_i[BYTE_W-1:0];
                    ctl_d.quo   = '0;
                    ctl_d.rem   = '0;
                    ctl_d.cnt   = '0;
                end
            end
            default: begin
                if (ctl_q.op == ADJ_SPLIT) begin
                    ctl_d.dvd = {ctl_q.dvd[BYTE_W-2:0], 1'b0};
                    ctl_d.quo = {ctl_q.quo[BYTE_W-3:0], q_bit};
                    ctl_d.rem = rem_nxt;
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.cnt == CNT_W'(BYTE_W - 1)) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.res  = cand_res;
                        ctl_d.fl   = cand_fl;
                    end
                end else begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = cand_res;
                    ctl_d.fl   = cand_fl;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o = (ctl_q.st == ST_BUSY);
    assign done_o = ctl_q.done;
    assign res_o  = ctl_q.res;
    assign cf_o   = ctl_q.fl.cf;
    assign af_o   = ctl_q.fl.af;
    assign of_o   = ctl_q.fl.of;
    assign sf_o   = ctl_q.fl.sf;
    assign zf_o   = ctl_q.fl.zf;
    assign pf_o   = ctl_q.fl.pf;

endmodule

// File: rtl/ascii_adj_chk.sv
module ascii_adj_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] res_o,
    input logic        cf_o,
    input logic        af_o,
    input logic        of_o,
    input logic        sf_o
);

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(res_o));

    // R1 R2 R6
    af_cf_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (af_o == cf_o));

    // R3 R6
    sign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sf_o) |-> (!cf_o && !of_o));

endmodule

bind ascii_adj_unit ascii_adj_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .done_o (done_o),
    .res_o  (res_o),
    .cf_o   (cf_o),
    .af_o   (af_o),
    .of_o   (of_o),
    .sf_o   (sf_o)
);

// File: tb/ascii_adj_unit_bench.sv
`timescale 1ns/1ps
module ascii_adj_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [15:0] val_i = 16'h0;
    logic        af_i = 1'b0;
    logic        of_i = 1'b0;
    logic        busy_o, done_o;
    logic [15:0] res_o;
    logic        cf_o, af_o, of_o, sf_o, zf_o, pf_o;

    always #4 clk = ~clk;

    ascii_adj_unit u_ascii_adj_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .val_i(val_i),
        .af_i(af_i), .of_i(of_i), .busy_o(busy_o), .done_o(done_o), .res_o(res_o),
        .cf_o(cf_o), .af_o(af_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o)
    );

    typedef struct {
        logic [15:0] res;
        logic [5:0]  fl;   // cf af of sf zf pf
        int          due;
        string       rtag;
        string       ftag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] last_res = 16'h0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(input logic [1:0] op, input logic [15:0] v,
                                   input logic af, input logic ofl);
        exp_t e;
        logic c;
        logic [15:0] r;
        logic cf, a, o, s;
        c = (v[3:0] > 4'd9) || af;
        case (op)
            2'd0: begin r = (c ? v + 16'h0106 : v) & 16'hFF0F; cf = c; a = c; o = ofl; s = 1'b0;
                        e.rtag = "R1"; e.ftag = "R3"; end
            2'd1: begin r = (c ? v - 16'h0106 : v) & 16'hFF0F; cf = c; a = c; o = ofl; s = 1'b0;
                        e.rtag = "R2"; e.ftag = "R3"; end
            2'd2: begin r = {8'h00, 8'(int'(v[7:0]) + 10 * int'(v[15:8]))};
                        cf = 0; a = 0; o = 0; s = r[7]; e.rtag = "R4"; e.ftag = "R6"; end
            default: begin r = {8'(v[7:0] / 8'd10), 8'(v[7:0] % 8'd10)};
                        cf = 0; a = 0; o = 0; s = r[7]; e.rtag = "R5"; e.ftag = "R6"; end
        endcase
        e.res = r;
        e.fl  = {cf, a, o, s, (r == 16'h0), ~^r[7:0]};
        e.due = (op == 2'd3) ? 8 : 1;
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [15:0] v,
                         input logic af, input logic ofl);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        e = model(op, v, af, ofl);
        e.due = e.due + cyc + 1;
        exp_q.push_back(e);
        start_i = 1'b1; op_i = op; val_i = v; af_i = af; of_i = ofl;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // R8: start pulse while busy, with different operands
    task automatic poke();
        start_i = 1'b1; op_i = 2'd2; val_i = 16'hFFFF; af_i = 1'b1; of_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 32'(res_o), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(res_o == e.res, e.rtag, "result", 32'(res_o), 32'(e.res));
                    check({cf_o, af_o, of_o, sf_o, zf_o, pf_o} == e.fl, e.ftag, "flags",
                          32'({cf_o, af_o, of_o, sf_o, zf_o, pf_o}), 32'(e.fl));
                    check(cyc == e.due, "R7", "done cycle", 32'(cyc), 32'(e.due));
                end
                last_res = res_o;
            end else begin
                check(res_o == last_res, "R10", "held result", 32'(res_o), 32'(last_res));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check({busy_o, done_o, res_o, cf_o, af_o, of_o, sf_o, zf_o, pf_o} == '0, "R9",
              "reset outputs", 32'({busy_o, done_o, res_o}), 32'h0);
        rst_n = 1'b1;

        // R1 boundaries
        issue(2'd0, 16'h0009, 1'b0, 1'b0);
        issue(2'd0, 16'h000A, 1'b0, 1'b1);
        issue(2'd0, 16'h0203, 1'b1, 1'b0);
        issue(2'd0, 16'hFF0A, 1'b0, 1'b0);
        issue(2'd0, 16'h12F5, 1'b0, 1'b1);
        // R2 boundaries
        issue(2'd1, 16'h0005, 1'b1, 1'b0);
        issue(2'd1, 16'h010A, 1'b0, 1'b1);
        issue(2'd1, 16'h3479, 1'b0, 1'b0);
        // R4
        issue(2'd2, 16'h0909, 1'b0, 1'b1);
        issue(2'd2, 16'hFFFF, 1'b1, 1'b1);
        issue(2'd2, 16'h0000, 1'b0, 1'b0);
        // R8 pokes during short and long operations
        issue(2'd0, 16'h000B, 1'b0, 1'b0);
        poke();
        issue(2'd3, 16'h00C7, 1'b0, 1'b0);
        poke();
        repeat (3) poke();
        // R5 exhaustive sweep of the low byte
        for (int i = 0; i < 256; i++) begin
            issue(2'd3, {8'($urandom), 8'(i)}, 1'($urandom), 1'($urandom));
        end
        // mixed random operations
        for (int i = 0; i < 300; i++) begin
            issue(2'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7", "pending results", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule